// File: doc/BRIEF.md
# Stream Buffer with Fall-Through Queue

This block buffers an AXI4-Stream flow between an upstream sender and a downstream receiver that run on the same clock. Every field of an incoming beat is stored, apart from the two handshake wires. That covers the data, byte qualifiers, end-of-packet marker, user bits and stream identifier. The fields are held as one wide entry in an internal queue and handed back out in arrival order. The queue works in fall-through fashion: the oldest stored beat is already on the output and marked valid, so the receiver does not have to request it first.

Back-pressure comes straight from the queue state. The input accepts beats whenever a slot is free. The output offers a beat whenever one is stored. The block also reports the current fill level, plus two threshold outputs whose trip points are set by parameters: one for nearly full and one for nearly empty. The reset is asynchronous and active low, and the block starts accepting data on the first cycle after reset is released.

Top module: `axis_stream_buffer`

## Requirements
- R1: A beat is taken on the input only in a cycle where `s_tvalid` and `s_tready` are both high, and leaves on the output only where `m_tvalid` and `m_tready` are both high. `level` rises by one after a lone input transfer and falls by one after a lone output transfer.
- R2: Out of reset, `s_tready` is high exactly when `level` is below DEPTH. When the queue is full it is low, and a beat offered then is dropped: it changes neither the level nor the data later read out.
- R3: `m_tvalid` is high exactly when `level` is nonzero.
- R4: Beats leave in the order they arrived, with every field (`tdata`, `tstrb`, `tlast`, `tuser`, `tid`) intact. Internally each entry packs the fields with `tid` at the top, then `tuser`, `tlast` and `tstrb`, and `tdata` in the lowest bits.
- R5: A beat written into an empty queue is shown on the `m_*` outputs with `m_tvalid` high in the very next cycle, without any read request.
- R6: While `rst_n` is low, `s_tready` and `m_tvalid` are low and `level` is zero, whatever the clock does. Asserting `rst_n` low in the middle of a run discards every stored beat.
- R7: `s_tready` is low during reset and goes high in the first cycle after `rst_n` is released.
- R8: When an input transfer and an output transfer happen in the same cycle, `level` does not change.
- R9: While `m_tvalid` is high and `m_tready` is low, all `m_*` payload outputs keep their values into the next cycle.
- R10: `near_full` is high exactly when `level` is at least FULL_MARK.
- R11: `near_empty` is high exactly when `level` is at most EMPTY_MARK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both stream sides |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_tdata | input | DATA_W | Incoming payload |
| s_tstrb | input | DATA_W/8 | Incoming byte qualifiers |
| s_tlast | input | 1 | Incoming end-of-packet marker |
| s_tuser | input | USER_W | Incoming user bits |
| s_tid | input | ID_W | Incoming stream identifier |
| s_tvalid | input | 1 | Sender has a beat |
| s_tready | output | 1 | Buffer can take a beat |
| m_tdata | output | DATA_W | Outgoing payload |
| m_tstrb | output | DATA_W/8 | Outgoing byte qualifiers |
| m_tlast | output | 1 | Outgoing end-of-packet marker |
| m_tuser | output | USER_W | Outgoing user bits |
| m_tid | output | ID_W | Outgoing stream identifier |
| m_tvalid | output | 1 | Buffer offers a beat |
| m_tready | input | 1 | Receiver takes the offered beat |
| level | output | $clog2(DEPTH+1) | Number of stored beats |
| near_full | output | 1 | Level at or above FULL_MARK |
| near_empty | output | 1 | Level at or below EMPTY_MARK |

## Verification
An input transfer and an output transfer can land on the same clock edge. The level must then stay put, while the new beat goes to the tail and the head advances. The bench provokes this by holding both valid and ready high for long runs at partial fill, and again from a full queue. There, the output transfer frees a slot but the input must still be refused that cycle. A behavioural queue in the bench predicts the level, both handshakes and the head beat every cycle, and any difference from the design is counted as a mismatch.

// File: rtl/axsb_pkg.sv
package axsb_pkg;

  // Operation encoding applied to the queue in one cycle: {push, pop}
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } axsb_op_e;

  function automatic int unsigned strb_width(input int unsigned data_w);
    return (data_w + 7) / 8;
  endfunction

  function automatic int unsigned entry_width(input int unsigned data_w,
                                              input int unsigned user_w,
                                              input int unsigned id_w);
    return id_w + user_w + 1 + strb_width(data_w) + data_w;
  endfunction

endpackage

// File: rtl/axsb_pack.sv
// Joins the input beat fields into one queue entry and splits the head entry
// back into output fields. Layout from top bit down: id, user, last, strb, data.
module axsb_pack
  import axsb_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned USER_W = 4,
  parameter int unsigned ID_W   = 4,
  localparam int unsigned STRB_W = strb_width(DATA_W),
  localparam int unsigned WORD_W = entry_width(DATA_W, USER_W, ID_W)
) (
  input  logic [DATA_W-1:0] in_data,
  input  logic [STRB_W-1:0] in_strb,
  input  logic              in_last,
  input  logic [USER_W-1:0] in_user,
  input  logic [ID_W-1:0]   in_id,
  output logic [WORD_W-1:0] entry_o,
  input  logic [WORD_W-1:0] entry_i,
  output logic [DATA_W-1:0] out_data,
  output logic [STRB_W-1:0] out_strb,
  output logic              out_last,
  output logic [USER_W-1:0] out_user,
  output logic [ID_W-1:0]   out_id
);

  always_comb begin
    entry_o = {in_id, in_user, in_last, in_strb, in_data};
    {out_id, out_user, out_last, out_strb, out_data} = entry_i;
  end

endmodule

// File: rtl/axsb_store.sv
// Register-array queue with fall-through head, circular pointers and a fill counter.
module axsb_store
  import axsb_pkg::*;
#(
  parameter int unsigned WORD_W = 45,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] head_word,
  output logic [CNT_W-1:0]  fill,
  output logic              has_room,
  output logic              has_data
);

  logic [WORD_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, wr_ptr_nxt;
  logic [PTR_W-1:0]  rd_ptr, rd_ptr_nxt;
  logic [CNT_W-1:0]  cnt, cnt_nxt;
  axsb_op_e          op;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    op         = axsb_op_e'({push, pop});
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    cnt_nxt    = cnt;
    if (push) wr_ptr_nxt = advance(wr_ptr);
    if (pop)  rd_ptr_nxt = advance(rd_ptr);
    case (op)
      OP_PUSH: cnt_nxt = cnt + 1'b1;
      OP_POP:  cnt_nxt = cnt - 1'b1;
      default: cnt_nxt = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      cnt    <= cnt_nxt;
    end
  end

  // Storage carries no reset; only written slots are ever read as valid.
  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= wr_word;
  end

  always_comb begin
    head_word = slots[rd_ptr];
    fill      = cnt;
    has_room  = (cnt != CNT_W'(DEPTH));
    has_data  = (cnt != '0);
  end

endmodule

// File: rtl/axsb_marks.sv
// Threshold indicators derived from the fill level.
module axsb_marks #(
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned FULL_MARK  = 6,
  parameter int unsigned EMPTY_MARK = 2
) (
  input  logic [CNT_W-1:0] fill,
  output logic             high_mark,
  output logic             low_mark
);

  always_comb begin
    high_mark = (fill >= CNT_W'(FULL_MARK));
    low_mark  = (fill <= CNT_W'(EMPTY_MARK));
  end

endmodule

// File: rtl/axis_stream_buffer.sv
module axis_stream_buffer
  import axsb_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned USER_W     = 4,
  parameter int unsigned ID_W       = 4,
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned FULL_MARK  = 6,
  parameter int unsigned EMPTY_MARK = 2,
  localparam int unsigned STRB_W = strb_width(DATA_W),
  localparam int unsigned WORD_W = entry_width(DATA_W, USER_W, ID_W),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic [STRB_W-1:0] s_tstrb,
  input  logic              s_tlast,
  input  logic [USER_W-1:0] s_tuser,
  input  logic [ID_W-1:0]   s_tid,
  input  logic              s_tvalid,
  output logic              s_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic [STRB_W-1:0] m_tstrb,
  output logic              m_tlast,
  output logic [USER_W-1:0] m_tuser,
  output logic [ID_W-1:0]   m_tid,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [CNT_W-1:0]  level,
  output logic              near_full,
  output logic              near_empty
);

  logic              awake, awake_nxt;
  logic              room, present;
  logic              push, pop;
  logic [WORD_W-1:0] in_entry, head_entry;

  // Input side stays closed until the first edge after reset release
  always_comb awake_nxt = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) awake <= 1'b0;
    else        awake <= awake_nxt;
  end

  always_comb begin
    s_tready = awake & room;
    m_tvalid = present;
    push     = s_tvalid & s_tready;
    pop      = m_tvalid & m_tready;
  end

  axsb_pack #(
    .DATA_W (DATA_W),
    .USER_W (USER_W),
    .ID_W   (ID_W)
  ) u_pack (
    .in_data  (s_tdata),
    .in_strb  (s_tstrb),
    .in_last  (s_tlast),
    .in_user  (s_tuser),
    .in_id    (s_tid),
    .entry_o  (in_entry),
    .entry_i  (head_entry),
    .out_data (m_tdata),
    .out_strb (m_tstrb),
    .out_last (m_tlast),
    .out_user (m_tuser),
    .out_id   (m_tid)
  );

  axsb_store #(
    .WORD_W (WORD_W),
    .DEPTH  (DEPTH)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop       (pop),
    .wr_word   (in_entry),
    .head_word (head_entry),
    .fill      (level),
    .has_room  (room),
    .has_data  (present)
  );

  axsb_marks #(
    .CNT_W      (CNT_W),
    .FULL_MARK  (FULL_MARK),
    .EMPTY_MARK (EMPTY_MARK)
  ) u_marks (
    .fill      (level),
    .high_mark (near_full),
    .low_mark  (near_empty)
  );

endmodule

// File: rtl/axsb_checker.sv
module axsb_checker #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned USER_W     = 4,
  parameter int unsigned ID_W       = 4,
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned FULL_MARK  = 6,
  parameter int unsigned EMPTY_MARK = 2,
  localparam int unsigned STRB_W = (DATA_W + 7) / 8,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_tvalid,
  input logic              s_tready,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic [DATA_W-1:0] m_tdata,
  input logic [STRB_W-1:0] m_tstrb,
  input logic              m_tlast,
  input logic [USER_W-1:0] m_tuser,
  input logic [ID_W-1:0]   m_tid,
  input logic [CNT_W-1:0]  level,
  input logic              near_full,
  input logic              near_empty
);

  logic take, give;
  always_comb begin
    take = s_tvalid && s_tready;
    give = m_tvalid && m_tready;
  end

  p_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !give) |=> (level == $past(level) + 1'b1));

  p_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (give && !take) |=> (level == $past(level) - 1'b1));

  p_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (level == CNT_W'(DEPTH)) |-> !s_tready);

  p_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s_tready |-> (level < CNT_W'(DEPTH)));

  p_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (level != '0) |-> m_tvalid);

  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> !m_tvalid);

  p_reset_r6: assert property (@(posedge clk)
    !rst_n |-> (!s_tready && !m_tvalid && level == '0));

  p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && level < CNT_W'(DEPTH)) |-> s_tready);

  p_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && give) |=> $stable(level));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tstrb)
                                 && $stable(m_tlast) && $stable(m_tuser) && $stable(m_tid)));

  p_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    near_full == (level >= CNT_W'(FULL_MARK)));

  p_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    near_empty == (level <= CNT_W'(EMPTY_MARK)));

endmodule

bind axis_stream_buffer axsb_checker #(
  .DATA_W     (DATA_W),
  .USER_W     (USER_W),
  .ID_W       (ID_W),
  .DEPTH      (DEPTH),
  .FULL_MARK  (FULL_MARK),
  .EMPTY_MARK (EMPTY_MARK)
) i_axsb_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_tvalid   (s_tvalid),
  .s_tready   (s_tready),
  .m_tvalid   (m_tvalid),
  .m_tready   (m_tready),
  .m_tdata    (m_tdata),
  .m_tstrb    (m_tstrb),
  .m_tlast    (m_tlast),
  .m_tuser    (m_tuser),
  .m_tid      (m_tid),
  .level      (level),
  .near_full  (near_full),
  .near_empty (near_empty)
);

// File: tb/test_axis_stream_buffer.sv
module test_axis_stream_buffer;

  localparam int DATA_W = 32;
  localparam int USER_W = 4;
  localparam int ID_W   = 4;
  localparam int STRB_W = 4;
  localparam int DEPTH  = 8;
  localparam int FULL_MARK  = 6;
  localparam int EMPTY_MARK = 2;
  localparam int CNT_W  = 4;

  typedef struct {
    logic [DATA_W-1:0] d;
    logic [STRB_W-1:0] s;
    logic              l;
    logic [USER_W-1:0] u;
    logic [ID_W-1:0]   i;
  } beat_t;

  logic clk = 1'b0;
  logic rst_n;
  logic [DATA_W-1:0] s_tdata = '0;
  logic [STRB_W-1:0] s_tstrb = '0;
  logic              s_tlast = 1'b0;
  logic [USER_W-1:0] s_tuser = '0;
  logic [ID_W-1:0]   s_tid = '0;
  logic              s_tvalid = 1'b0;
  logic              s_tready;
  logic [DATA_W-1:0] m_tdata;
  logic [STRB_W-1:0] m_tstrb;
  logic              m_tlast;
  logic [USER_W-1:0] m_tuser;
  logic [ID_W-1:0]   m_tid;
  logic              m_tvalid;
  logic              m_tready = 1'b0;
  logic [CNT_W-1:0]  level;
  logic              near_full, near_empty;

  always #2.5 clk = ~clk;

  axis_stream_buffer #(
    .DATA_W(DATA_W), .USER_W(USER_W), .ID_W(ID_W), .DEPTH(DEPTH),
    .FULL_MARK(FULL_MARK), .EMPTY_MARK(EMPTY_MARK)
  ) i_axis_stream_buffer (
    .clk(clk), .rst_n(rst_n),
    .s_tdata(s_tdata), .s_tstrb(s_tstrb), .s_tlast(s_tlast), .s_tuser(s_tuser),
    .s_tid(s_tid), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tstrb(m_tstrb), .m_tlast(m_tlast), .m_tuser(m_tuser),
    .m_tid(m_tid), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .level(level), .near_full(near_full), .near_empty(near_empty)
  );

  // Behavioural reference: a queue of beats and an "accepting" flag
  beat_t model_q[$];
  bit    model_on = 1'b0;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_q.delete();
      model_on = 1'b0;
    end else begin
      bit    acc, dep;
      beat_t b;
      acc = s_tvalid && model_on && (model_q.size() < DEPTH);
      dep = (model_q.size() > 0) && m_tready;
      b.d = s_tdata; b.s = s_tstrb; b.l = s_tlast; b.u = s_tuser; b.i = s_tid;
      if (dep) void'(model_q.pop_front());
      if (acc) model_q.push_back(b);
      model_on = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      int sz;
      sz = model_q.size();
      if (!rst_n) begin
        // R6: reset state
        chk(!s_tready && !m_tvalid && level == '0, "R6 reset state",
            {s_tready, m_tvalid, level}, 64'h0);
      end else begin
        bit exp_rdy;
        exp_rdy = model_on && (sz < DEPTH);
        chk(s_tready === exp_rdy, "R2/R7 s_tready", 64'(s_tready), 64'(exp_rdy));
        chk(m_tvalid === (sz > 0), "R3/R5 m_tvalid", 64'(m_tvalid), 64'(sz > 0));
        chk(level === CNT_W'(sz), "R1/R8 level", 64'(level), 64'(sz));
        chk(near_full === (sz >= FULL_MARK), "R10 near_full", 64'(near_full), 64'(sz >= FULL_MARK));
        chk(near_empty === (sz <= EMPTY_MARK), "R11 near_empty", 64'(near_empty), 64'(sz <= EMPTY_MARK));
        if (sz > 0) begin
          logic [63:0] a, e;
          a = 64'({m_tid, m_tuser, m_tlast, m_tstrb, m_tdata});
          e = 64'({model_q[0].i, model_q[0].u, model_q[0].l, model_q[0].s, model_q[0].d});
          chk(a === e, "R4/R9 head beat", a, e);
        end
      end
    end
  end

  task automatic cyc(input bit v, input bit r);
    @(negedge clk);
    s_tvalid = v;
    m_tready = r;
    s_tdata  = $urandom;
    s_tstrb  = STRB_W'($urandom);
    s_tlast  = 1'($urandom);
    s_tuser  = USER_W'($urandom);
    s_tid    = ID_W'($urandom);
  endtask

  task automatic report;
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual=running expected=done");
      report();
    end
  end

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (4) cyc(0, 0);
    @(negedge clk) rst_n = 1'b1;            // R7: ready must rise next cycle
    cyc(0, 0);
    // R5: single beat into empty queue falls through
    cyc(1, 0);
    cyc(0, 0); cyc(0, 0);
    // R2: fill past capacity; extra beats must be refused
    repeat (12) cyc(1, 0);
    // R9: hold with receiver stalled
    repeat (3) cyc(0, 0);
    // R8: from full, simultaneous read and offered write
    repeat (3) cyc(1, 1);
    repeat (4) cyc(0, 1);
    repeat (12) cyc(1, 1);
    repeat (10) cyc(0, 1);
    // Mixed traffic at three bias settings
    for (int k = 0; k < 3; k++) begin
      for (int n = 0; n < 1500; n++) begin
        int pv, pr;
        pv = (k == 0) ? 80 : (k == 1) ? 50 : 30;
        pr = (k == 0) ? 30 : (k == 1) ? 50 : 85;
        cyc(($urandom % 100) < pv, ($urandom % 100) < pr);
      end
    end
    // R6: asynchronous reset mid-run with beats stored
    repeat (6) cyc(1, 0);
    #1 rst_n = 1'b0;
    repeat (3) cyc(1, 1);
    @(negedge clk) begin rst_n = 1'b1; s_tvalid = 1'b0; m_tready = 1'b0; end
    repeat (2) cyc(0, 0);
    repeat (20) cyc(1, 1);
    repeat (10) cyc(0, 1);
    @(negedge clk);
    @(posedge clk);
    report();
  end

endmodule